// File: doc/BRIEF.md
# Drive Step and Head Timer

This block turns the three timing values of a disk controller's setup command into drive control strobes. When a seek or recalibrate move asks for a number of steps, it emits that many step strobes at a programmed spacing. After the last strobe it waits one more step interval and then signals that the move has finished. It also manages the read/write head. A read/write execution phase that finds the head unloaded raises the head-load line and holds off the transfer for the programmed settle time. When the phase ends, the head stays loaded for a programmed idle time before it is released.

All three intervals are counted in a common time unit. One unit lasts `2^(UNIT_SHIFT + rate_sel)` clock cycles, so each slower data-rate setting doubles every duration. Each interval captures its setup value and the rate when it starts, so software may reprogram the block while a move or a head wait is in progress. The same timing applies to both bit encodings; the encoding is not an input. Command decoding is done elsewhere, and this block sees only one-cycle request strobes.

Top module: `step_head_timer`

## Requirements
- R1: While reset is asserted, and until the first request after reset, `step_pulse`, `step_done`, `step_busy`, `head_load` and `xfer_ready` are all 0.
- R2: Consecutive step strobes are exactly `(16 - step_rate) * 2^(UNIT_SHIFT + rate_sel)` cycles apart. A `step_rate` of 0 gives 16 units.
- R3: When `step_req` is sampled with a nonzero `step_count`, the first step strobe is high in the second cycle after the sampling edge. Exactly `step_count` strobes follow, and each is one cycle wide.
- R4: `step_done` is a one-cycle pulse that comes exactly one step period after the last strobe. `step_busy` is 1 from the cycle after acceptance up to, but not including, the `step_done` cycle.
- R5: The block ignores `step_req` when `step_count` is 0, and also while a move is in progress. An ignored request changes no strobe, no done pulse and no busy indication.
- R6: Raising `rate_sel` by one doubles the step, settle and idle durations. A `rate_sel` of 0 is the fastest setting.
- R7: A `rw_start` that finds the head unloaded raises `head_load` in the next cycle. `xfer_ready` then rises exactly `load_time * 2^(UNIT_SHIFT + rate_sel)` cycles after `head_load`, where a `load_time` of 0 means 128 units.
- R8: `rw_end` during an active transfer drops `xfer_ready` in the next cycle. `head_load` then falls exactly `unload_time` units later, where an `unload_time` of 0 means 16 units.
- R9: A `rw_start` that arrives while the idle timeout is still running cancels the unload and skips the settle wait. `xfer_ready` rises in the next cycle and `head_load` never drops.
- R10: Each interval uses the setup value it captured when it started. A change to `step_rate` during a move, or to `unload_time` during the idle wait, does not alter that interval.
- R11: The block ignores `rw_start` while the head is settling or a transfer is active, and ignores `rw_end` while the head is unloaded or settling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| step_rate | input | 4 | Step spacing code; spacing is 16 minus this value, in units |
| unload_time | input | 4 | Idle time before head release, in units (0 = 16) |
| load_time | input | 7 | Head settle time, in units (0 = 128) |
| rate_sel | input | 2 | Data-rate selection; each step up doubles the unit |
| step_req | input | 1 | One-cycle request to start a move |
| step_count | input | 8 | Number of step strobes for the requested move |
| rw_start | input | 1 | One-cycle marker: read/write execution phase begins |
| rw_end | input | 1 | One-cycle marker: read/write execution phase ends |
| step_pulse | output | 1 | One-cycle step strobe |
| step_done | output | 1 | One-cycle pulse when a move has finished |
| step_busy | output | 1 | A move is in progress |
| head_load | output | 1 | Head-load line to the drive |
| xfer_ready | output | 1 | Settle time has elapsed; data transfer may proceed |

## Verification
Every result is registered. The k-th step strobe of a move is due `1 + (k-1)·P` cycles after the edge that samples the request, and `step_done` is due at `1 + N·P`. `xfer_ready` is due `HLT` cycles after a fresh `rw_start` edge, or one cycle after it when it cancels a pending unload. The head-load fall is due `HUT` cycles after the `rw_end` edge. The bench drives and samples on the falling edge and numbers each cycle from the edge that took the stimulus. It compares every output in every cycle of each window against those closed-form positions, so a strobe that is one cycle early or late counts as a mismatch. It also runs a few cycles past the window, so a stray extra strobe is caught.

// File: rtl/sht_pkg.sv
package sht_pkg;

  typedef enum logic [1:0] {
    HD_IDLE   = 2'd0,
    HD_SETTLE = 2'd1,
    HD_ACTIVE = 2'd2,
    HD_HOLD   = 2'd3
  } head_state_e;

  // cycles in an interval of 'units' time units at a given scale exponent
  function automatic int unsigned sht_cycles(input int unsigned units,
                                             input int unsigned scale);
    return units << scale;
  endfunction

endpackage

// File: rtl/sht_step_engine.sv
module sht_step_engine
  import sht_pkg::*;
#(
  parameter int UNIT_SHIFT = 1,
  parameter int RATE_W     = 2,
  parameter int NUM_W      = 8,
  parameter int CNT_W      = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        step_rate,
  input  logic [RATE_W-1:0] rate_sel,
  input  logic              step_req,
  input  logic [NUM_W-1:0]  step_count,
  output logic              step_pulse,
  output logic              step_done,
  output logic              step_busy
);

  logic              busy_q, busy_d;
  logic [NUM_W-1:0]  left_q, left_d;
  logic [CNT_W-1:0]  wait_q, wait_d;
  logic [CNT_W-1:0]  per_q, per_d;
  logic              pulse_q, pulse_d;
  logic              done_q, done_d;
  logic [CNT_W-1:0]  period_now;
  logic [4:0]        units;

  assign units      = 5'd16 - {1'b0, step_rate};
  assign period_now = CNT_W'(sht_cycles(32'(units), UNIT_SHIFT + int'(rate_sel)));

  always_comb begin
    busy_d  = busy_q;
    left_d  = left_q;
    wait_d  = wait_q;
    per_d   = per_q;
    pulse_d = 1'b0;
    done_d  = 1'b0;
    if (!busy_q) begin
      if (step_req && (step_count != '0)) begin
        busy_d = 1'b1;
        left_d = step_count;
        wait_d = '0;
        per_d  = period_now;
      end
    end else if (wait_q == '0) begin
      if (left_q != '0) begin
        pulse_d = 1'b1;
        left_d  = left_q - 1'b1;
        wait_d  = per_q - 1'b1;
      end else begin
        done_d = 1'b1;
        busy_d = 1'b0;
      end
    end else begin
      wait_d = wait_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      left_q  <= '0;
      wait_q  <= '0;
      per_q   <= '0;
      pulse_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      busy_q  <= busy_d;
      left_q  <= left_d;
      wait_q  <= wait_d;
      per_q   <= per_d;
      pulse_q <= pulse_d;
      done_q  <= done_d;
    end
  end

  assign step_pulse = pulse_q;
  assign step_done  = done_q;
  assign step_busy  = busy_q;

  // R4
  done_clears_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_done |-> !step_busy);

  // R5
  zero_count_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_busy && step_req && step_count == '0) |=> !step_busy && !step_pulse);

  // R3
  pulse_inside_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_pulse |-> step_busy && !step_done);

endmodule

// File: rtl/sht_head_engine.sv
module sht_head_engine
  import sht_pkg::*;
#(
  parameter int UNIT_SHIFT = 1,
  parameter int RATE_W     = 2,
  parameter int CNT_W      = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        unload_time,
  input  logic [6:0]        load_time,
  input  logic [RATE_W-1:0] rate_sel,
  input  logic              rw_start,
  input  logic              rw_end,
  output logic              head_load,
  output logic              xfer_ready
);

  head_state_e      st_q, st_d;
  logic [CNT_W-1:0] tmr_q, tmr_d;
  logic [7:0]       hlt_units;
  logic [4:0]       hut_units;
  logic [CNT_W-1:0] hlt_cyc, hut_cyc;

  assign hlt_units = (load_time == '0) ? 8'd128 : {1'b0, load_time};
  assign hut_units = (unload_time == '0) ? 5'd16 : {1'b0, unload_time};
  assign hlt_cyc   = CNT_W'(sht_cycles(32'(hlt_units), UNIT_SHIFT + int'(rate_sel)));
  assign hut_cyc   = CNT_W'(sht_cycles(32'(hut_units), UNIT_SHIFT + int'(rate_sel)));

  always_comb begin
    st_d  = st_q;
    tmr_d = tmr_q;
    unique case (st_q)
      HD_IDLE: begin
        if (rw_start) begin
          st_d  = HD_SETTLE;
          tmr_d = hlt_cyc - 1'b1;
        end
      end
      HD_SETTLE: begin
        if (tmr_q == '0) st_d = HD_ACTIVE;
        else             tmr_d = tmr_q - 1'b1;
      end
      HD_ACTIVE: begin
        if (rw_end) begin
          st_d  = HD_HOLD;
          tmr_d = hut_cyc - 1'b1;
        end
      end
      HD_HOLD: begin
        if (rw_start)           st_d = HD_ACTIVE;
        else if (tmr_q == '0)   st_d = HD_IDLE;
        else                    tmr_d = tmr_q - 1'b1;
      end
      default: st_d = HD_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= HD_IDLE;
      tmr_q <= '0;
    end else begin
      st_q  <= st_d;
      tmr_q <= tmr_d;
    end
  end

  assign head_load  = (st_q != HD_IDLE);
  assign xfer_ready = (st_q == HD_ACTIVE);

  // R8
  ready_needs_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_ready |-> head_load);

  // R9
  hold_restart_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == HD_HOLD && rw_start) |=> xfer_ready);

  // R7
  fresh_load_waits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!head_load && rw_start) |=> head_load && !xfer_ready);

endmodule

// File: rtl/step_head_timer.sv
module step_head_timer #(
  parameter int UNIT_SHIFT = 1,
  parameter int RATE_W     = 2,
  parameter int NUM_W      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        step_rate,
  input  logic [3:0]        unload_time,
  input  logic [6:0]        load_time,
  input  logic [RATE_W-1:0] rate_sel,
  input  logic              step_req,
  input  logic [NUM_W-1:0]  step_count,
  input  logic              rw_start,
  input  logic              rw_end,
  output logic              step_pulse,
  output logic              step_done,
  output logic              step_busy,
  output logic              head_load,
  output logic              xfer_ready
);

  // widest interval: 128 units at the slowest rate
  localparam int MAX_SCALE = UNIT_SHIFT + (1 << RATE_W) - 1;
  localparam int CNT_W     = 8 + MAX_SCALE;

  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  sht_step_engine #(
    .UNIT_SHIFT(UNIT_SHIFT), .RATE_W(RATE_W), .NUM_W(NUM_W), .CNT_W(CNT_W)
  ) step_i (
    .clk(clk), .rst_n(rst_int_n), .step_rate(step_rate), .rate_sel(rate_sel),
    .step_req(step_req), .step_count(step_count),
    .step_pulse(step_pulse), .step_done(step_done), .step_busy(step_busy)
  );

  sht_head_engine #(
    .UNIT_SHIFT(UNIT_SHIFT), .RATE_W(RATE_W), .CNT_W(CNT_W)
  ) head_i (
    .clk(clk), .rst_n(rst_int_n), .unload_time(unload_time), .load_time(load_time),
    .rate_sel(rate_sel), .rw_start(rw_start), .rw_end(rw_end),
    .head_load(head_load), .xfer_ready(xfer_ready)
  );

endmodule

// File: tb/step_head_timer_tb_top.sv
module step_head_timer_tb_top;
  localparam int SH = 1;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] step_rate, unload_time;
  logic [6:0] load_time;
  logic [1:0] rate_sel;
  logic       step_req, rw_start, rw_end;
  logic [7:0] step_count;
  logic       step_pulse, step_done, step_busy, head_load, xfer_ready;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  step_head_timer dut_i (
    .clk(clk), .rst_n(rst_n), .step_rate(step_rate), .unload_time(unload_time),
    .load_time(load_time), .rate_sel(rate_sel), .step_req(step_req),
    .step_count(step_count), .rw_start(rw_start), .rw_end(rw_end),
    .step_pulse(step_pulse), .step_done(step_done), .step_busy(step_busy),
    .head_load(head_load), .xfer_ready(xfer_ready)
  );

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  function automatic int unit_cyc(input int rate);
    return 1 << (SH + rate);
  endfunction

  // one move; optional late step_rate change and a retrigger at c==3
  task automatic run_steps(input int srt, input int srt_late, input int rate,
                           input int n, input bit retrig, input string rq);
    int p, bad, act, exp;
    p = (16 - srt) * unit_cyc(rate);
    bad = 0; act = 0; exp = 0;
    @(negedge clk);
    step_rate = 4'(srt); rate_sel = 2'(rate); step_count = 8'(n); step_req = 1'b1;
    @(posedge clk);
    @(negedge clk);
    step_req = 1'b0;
    step_rate = 4'(srt_late);
    for (int c = 1; c <= n * p + 3; c++) begin
      if (retrig && c == 3) begin step_count = 8'd5; step_req = 1'b1; end
      if (retrig && c == 4) step_req = 1'b0;
      @(negedge clk);
      begin
        int ep, ed, eb, got, want;
        ep = (c <= 1 + (n - 1) * p && ((c - 1) % p) == 0) ? 1 : 0;
        ed = (c == 1 + n * p) ? 1 : 0;
        eb = (c < 1 + n * p) ? 1 : 0;
        got  = {step_busy, step_done, step_pulse};
        want = eb * 4 + ed * 2 + ep;
        if (got != want && bad == 0) begin act = got; exp = want; end
        if (got != want) bad++;
      end
    end
    chk(bad == 0, rq, act, exp);
  endtask

  // from unloaded: settle then active
  task automatic head_start(input int hlt, input int rate, input int rw_end_at,
                            input string rq);
    int h, bad, act, exp;
    h = ((hlt == 0) ? 128 : hlt) * unit_cyc(rate);
    bad = 0; act = 0; exp = 0;
    @(negedge clk);
    load_time = 7'(hlt); rate_sel = 2'(rate); rw_start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rw_start = 1'b0;
    for (int c = 0; c <= h + 2; c++) begin
      int got, want;
      if (c > 0) begin
        if (c == rw_end_at) rw_end = 1'b1;
        @(negedge clk);
        rw_end = 1'b0;
      end
      got  = {head_load, xfer_ready};
      want = 2 + ((c >= h) ? 1 : 0);
      if (got != want && bad == 0) begin act = got; exp = want; end
      if (got != want) bad++;
    end
    chk(bad == 0, rq, act, exp);
  endtask

  // from active: idle hold then release
  task automatic head_end(input int hut, input int hut_late, input int rate,
                          input string rq);
    int u, bad, act, exp;
    u = ((hut == 0) ? 16 : hut) * unit_cyc(rate);
    bad = 0; act = 0; exp = 0;
    @(negedge clk);
    unload_time = 4'(hut); rate_sel = 2'(rate); rw_end = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rw_end = 1'b0;
    unload_time = 4'(hut_late);
    for (int c = 0; c <= u + 2; c++) begin
      int got, want;
      if (c > 0) @(negedge clk);
      got  = {head_load, xfer_ready};
      want = (c < u) ? 2 : 0;
      if (got != want && bad == 0) begin act = got; exp = want; end
      if (got != want) bad++;
    end
    chk(bad == 0, rq, act, exp);
  endtask

  initial begin
    rst_n = 1'b0;
    step_rate = '0; unload_time = 4'd1; load_time = 7'd1; rate_sel = '0;
    step_req = 1'b0; step_count = '0; rw_start = 1'b0; rw_end = 1'b0;
    repeat (3) @(negedge clk);
    // R1: outputs quiet in reset
    chk({step_pulse, step_done, step_busy, head_load, xfer_ready} == 5'b0, "R1",
        {step_pulse, step_done, step_busy, head_load, xfer_ready}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk({step_pulse, step_done, step_busy, head_load, xfer_ready} == 5'b0, "R1",
        {step_pulse, step_done, step_busy, head_load, xfer_ready}, 0);

    // R2 R3 R4: every step-rate code at the fastest rate
    for (int s = 0; s < 16; s++) run_steps(s, s, 0, 2, 1'b0, "R2");
    // R3: single and multi-step moves
    run_steps(14, 14, 0, 1, 1'b0, "R3");
    run_steps(13, 13, 0, 4, 1'b0, "R4");
    // R6: every rate
    for (int r = 0; r < 4; r++) run_steps(12, 12, r, 3, 1'b0, "R6");
    // R10: rate code changed during a move
    run_steps(12, 0, 0, 3, 1'b0, "R10");
    // R5: retrigger while busy is ignored
    run_steps(12, 12, 0, 2, 1'b1, "R5");
    // R5: zero count ignored
    begin
      int seen;
      seen = 0;
      @(negedge clk); step_count = 8'd0; step_req = 1'b1;
      @(negedge clk); step_req = 1'b0;
      for (int c = 0; c < 40; c++) begin
        @(negedge clk);
        if (step_busy || step_pulse || step_done) seen++;
      end
      chk(seen == 0, "R5", seen, 0);
    end

    // R11: rw_end while unloaded is ignored
    begin
      int seen;
      seen = 0;
      @(negedge clk); rw_end = 1'b1;
      @(negedge clk); rw_end = 1'b0;
      for (int c = 0; c < 6; c++) begin
        @(negedge clk);
        if (head_load || xfer_ready) seen++;
      end
      chk(seen == 0, "R11", seen, 0);
    end

    // R7 R8: settle and idle sweeps
    for (int v = 1; v < 16; v++) begin
      head_start(v, 0, -1, "R7");
      head_end(v, v, 0, "R8");
    end
    head_start(0, 0, -1, "R7");
    head_end(0, 0, 0, "R8");
    // R6: settle/idle at every rate
    for (int r = 0; r < 4; r++) begin
      head_start(3, r, -1, "R6");
      head_end(2, 2, r, "R6");
    end
    head_start(0, 3, -1, "R6");
    head_end(0, 0, 3, "R6");
    // R11: rw_end during settle is ignored
    head_start(5, 0, 3, "R11");
    // R11: rw_start during active is ignored
    begin
      int seen;
      seen = 0;
      @(negedge clk); rw_start = 1'b1;
      @(negedge clk); rw_start = 1'b0;
      for (int c = 0; c < 5; c++) begin
        @(negedge clk);
        if (!(head_load && xfer_ready)) seen++;
      end
      chk(seen == 0, "R11", seen, 0);
    end
    // R10: idle time captured at rw_end
    head_end(3, 15, 0, "R10");
    // R9: restart during idle hold
    head_start(4, 0, -1, "R9");
    begin
      int bad;
      bad = 0;
      @(negedge clk); unload_time = 4'd6; rw_end = 1'b1;
      @(negedge clk); rw_end = 1'b0;
      for (int c = 0; c < 3; c++) begin
        @(negedge clk);
        if (!head_load || xfer_ready) bad++;
      end
      rw_start = 1'b1;
      @(negedge clk); rw_start = 1'b0;
      if (!(head_load && xfer_ready)) bad++;
      for (int c = 0; c < 20; c++) begin
        @(negedge clk);
        if (!(head_load && xfer_ready)) bad++;
      end
      chk(bad == 0, "R9", bad, 0);
    end
    head_end(1, 1, 0, "R8");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule